// File: doc/BRIEF.md
# Load Address and Data Formatting Unit

This unit carries out a single load for a 32-bit big-endian core. From the operand values that the register file supplies, it forms an effective address. The address is the sum of a base and an offset. The offset is either a sign-extended 16-bit displacement or an index register. A base field of zero means a literal zero base, not the contents of register zero.

For a memory load, the unit issues a one-cycle request for the aligned 32-bit word that holds the address. It then waits for the word to arrive. It picks out the addressed byte or halfword and produces a 32-bit destination value, formatted according to the load kind. An address-only operation returns the effective address directly and makes no memory access. Update forms also hand the effective address back for writing into the base register.

The unit checks each operation as it is accepted. Malformed forms and halfword accesses that would cross the end of the word produce an error pulse instead of register writes. One operation is in flight at a time. The `busy` output tells the issuing stage when a new operation will be taken.

Top module: `ld_addr_fmt`

## Requirements
- R1: With `op_idx`=0, the effective address (EA) is the base operand plus `op_disp` sign-extended from bit 15 to 32 bits, with wraparound modulo 2^32.
- R2: With `op_idx`=1, the EA is the base operand plus `op_index_val`, with wraparound modulo 2^32.
- R3: When `op_base_sel` is 0, the base operand is the constant 0 and `op_base_val` has no effect on the EA.
- R4: An accepted memory load drives `mem_req` high for exactly the one cycle after acceptance. In that cycle, `mem_addr` equals the EA with bits 1:0 cleared. Within the returned word, byte offset 0 (EA bits 1:0 = 0) is `mem_rdata[31:24]` and offset 3 is `mem_rdata[7:0]`.
- R5: `op_kind`=1 (byte, zero fill) returns the byte at the EA in bits 7:0, with bits 31:8 zero.
- R6: `op_kind`=3 (halfword, sign fill) returns the byte at EA in bits 15:8 and the byte at EA+1 in bits 7:0, with bit 15 copied into bits 31:16.
- R7: `op_kind`=2 (halfword, zero fill) returns the same bytes as R6, with bits 31:16 zero.
- R8: `op_kind`=4 (halfword, swapped) returns the byte at EA+1 in bits 15:8 and the byte at EA in bits 7:0, with bits 31:16 zero.
- R9: A load result appears as a one-cycle `res_we` pulse in the cycle after the clock edge at which `mem_rvalid` is sampled high while the unit waits. `res_sel` equals `op_dst_sel`. A `mem_rvalid` pulse while no load is waiting has no effect.
- R10: For an update form (`op_upd`=1) that completes a load, `upd_we` pulses in the same cycle as `res_we`, with `upd_sel` equal to `op_base_sel` and `upd_data` equal to the EA. Without `op_upd`, `upd_we` stays low.
- R11: `op_kind`=0 (address only) makes no memory request. In the cycle after acceptance it pulses `res_we`, with `res_data` equal to the EA.
- R12: Any of the following makes the unit pulse `bad_form` in the cycle after acceptance, with no register write and no memory request:
  - `op_kind` is 5, 6 or 7;
  - `op_kind`=0 with `op_base_sel`=0;
  - `op_kind`=0 with `op_upd`=1;
  - `op_upd`=1 with `op_base_sel`=0;
  - `op_upd`=1 with `op_base_sel` equal to `op_dst_sel`.
- R13: A halfword kind (2, 3 or 4) whose EA bits 1:0 equal 3 pulses `align_err` in the cycle after acceptance, with no memory request and no register write. A byte load at offset 3 completes normally.
- R14: `busy` is high from the cycle after a memory load is accepted up to, but not including, the cycle of its result. `op_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_kind | input | 3 | Load kind code (0 address, 1 byte, 2 half zero, 3 half sign, 4 half swapped) |
| op_idx | input | 1 | Offset from index register instead of displacement |
| op_upd | input | 1 | Update form: write EA back to the base register |
| op_base_sel | input | 5 | Base register number (0 = zero base) |
| op_dst_sel | input | 5 | Destination register number |
| op_base_val | input | 32 | Base register contents |
| op_index_val | input | 32 | Index register contents |
| op_disp | input | 16 | Signed displacement |
| mem_req | output | 1 | Word read request (one cycle) |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Load in flight; new operations not taken |
| res_we | output | 1 | Destination write strobe |
| res_sel | output | 5 | Destination register number |
| res_data | output | 32 | Destination value |
| upd_we | output | 1 | Base write-back strobe |
| upd_sel | output | 5 | Base register number for write-back |
| upd_data | output | 32 | Effective address for write-back |
| bad_form | output | 1 | Invalid operation form pulse |
| align_err | output | 1 | Word-crossing halfword pulse |

## Verification
Error pulses and address-only results are due one cycle after the accepting edge. In that same cycle, a memory load shows `mem_req` and `mem_addr`. A load's result and write-back are due one cycle after the edge that samples `mem_rvalid`, and the response delay is randomised from one to three cycles. The bench drives every input at a falling edge and samples at the next falling edge after the edge in question. Between a request and its response it also checks that `res_we` stays low and `busy` stays high. One cycle after each operation it confirms that no stray pulse follows, so a `mem_rvalid` seen while idle, or an offer made while busy, is shown to have had no effect.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;

   typedef enum logic [2:0] {
      LK_ADDR     = 3'd0,
      LK_BYTE_Z   = 3'd1,
      LK_HALF_Z   = 3'd2,
      LK_HALF_S   = 3'd3,
      LK_HALF_REV = 3'd4
   } ld_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } ld_state_e;

   localparam int unsigned BYTE_W = 8;

   function automatic logic kind_is_half(input logic [2:0] k);
      return (k == LK_HALF_Z) || (k == LK_HALF_S) || (k == LK_HALF_REV);
   endfunction

endpackage

// File: rtl/ld_ea_calc.sv
`timescale 1ns/1ps
module ld_ea_calc #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned DISP_W = 16,
   parameter int unsigned RSEL_W = 5
) (
   input  logic              use_index,
   input  logic [RSEL_W-1:0] base_sel,
   input  logic [XLEN-1:0]   base_val,
   input  logic [XLEN-1:0]   index_val,
   input  logic [DISP_W-1:0] disp,
   output logic [XLEN-1:0]   ea
);

   localparam int unsigned EXT_W = XLEN - DISP_W;

   logic [XLEN-1:0] base_eff;
   logic [XLEN-1:0] disp_ext;
   logic [XLEN-1:0] offset;

   generate
      if (EXT_W > 0) begin : g_ext
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_noext
         assign disp_ext = disp[XLEN-1:0];
      end
   endgenerate

   // a zero base field selects a literal zero, not a register
   assign base_eff = (base_sel == '0) ? '0 : base_val;
   assign offset   = use_index ? index_val : disp_ext;
   assign ea       = base_eff + offset;

endmodule

// File: rtl/ld_form_chk.sv
`timescale 1ns/1ps
module ld_form_chk
   import ld_pkg::*;
#(
   parameter int unsigned RSEL_W    = 5,
   parameter int unsigned LANE_AW   = 2,
   parameter bit          ALLOW_REV = 1'b1
) (
   input  logic [2:0]         kind,
   input  logic               upd,
   input  logic [RSEL_W-1:0]  base_sel,
   input  logic [RSEL_W-1:0]  dst_sel,
   input  logic [LANE_AW-1:0] ea_low,
   output logic               bad,
   output logic               misalign,
   output logic               addr_only
);

   logic rev_ok;
   logic kind_known;
   logic upd_bad;
   logic addr_bad;

   generate
      if (ALLOW_REV) begin : g_rev_on
         assign rev_ok = 1'b1;
      end else begin : g_rev_off
         assign rev_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      kind_known = (kind <= LK_HALF_REV) && ((kind != LK_HALF_REV) || rev_ok);
      upd_bad    = upd && ((base_sel == '0) || (base_sel == dst_sel));
      addr_bad   = (kind == LK_ADDR) && ((base_sel == '0) || upd);
      bad        = !kind_known || upd_bad || addr_bad;
      // a halfword starting in the last lane would spill into the next word
      misalign   = !bad && kind_is_half(kind) && (ea_low == '1);
      addr_only  = (kind == LK_ADDR);
   end

endmodule

// File: rtl/ld_lane_fmt.sv
`timescale 1ns/1ps
module ld_lane_fmt
   import ld_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0]              word,
   input  logic [$clog2(XLEN/8)-1:0]    off,
   input  logic [2:0]                   kind,
   output logic [XLEN-1:0]              data
);

   localparam int unsigned LANES   = XLEN / BYTE_W;
   localparam int unsigned LANE_AW = $clog2(LANES);
   localparam int unsigned HI_PAD  = XLEN - 2 * BYTE_W;
   localparam int unsigned B_PAD   = XLEN - BYTE_W;

   logic [BYTE_W-1:0]  lane [LANES];
   logic [LANE_AW-1:0] off_nx;
   logic [BYTE_W-1:0]  b_lo_addr;
   logic [BYTE_W-1:0]  b_hi_addr;

   // big-endian: lane 0 is the most significant byte of the word
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane[g] = word[XLEN-1-g*BYTE_W -: BYTE_W];
      end
   endgenerate

   assign off_nx    = off + LANE_AW'(1);
   assign b_lo_addr = lane[off];
   assign b_hi_addr = lane[off_nx];

   always_comb begin
      unique case (kind)
         LK_BYTE_Z:   data = {{B_PAD{1'b0}}, b_lo_addr};
         LK_HALF_Z:   data = {{HI_PAD{1'b0}}, b_lo_addr, b_hi_addr};
         LK_HALF_S:   data = {{HI_PAD{b_lo_addr[BYTE_W-1]}}, b_lo_addr, b_hi_addr};
         LK_HALF_REV: data = {{HI_PAD{1'b0}}, b_hi_addr, b_lo_addr};
         default:     data = '0;
      endcase
   end

endmodule

// File: rtl/ld_addr_fmt.sv
`timescale 1ns/1ps
module ld_addr_fmt
   import ld_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned DISP_W    = 16,
   parameter int unsigned RSEL_W    = 5,
   parameter bit          ALLOW_REV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_kind,
   input  logic              op_idx,
   input  logic              op_upd,
   input  logic [RSEL_W-1:0] op_base_sel,
   input  logic [RSEL_W-1:0] op_dst_sel,
   input  logic [XLEN-1:0]   op_base_val,
   input  logic [XLEN-1:0]   op_index_val,
   input  logic [DISP_W-1:0] op_disp,
   output logic              mem_req,
   output logic [XLEN-1:0]   mem_addr,
   input  logic              mem_rvalid,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic              busy,
   output logic              res_we,
   output logic [RSEL_W-1:0] res_sel,
   output logic [XLEN-1:0]   res_data,
   output logic              upd_we,
   output logic [RSEL_W-1:0] upd_sel,
   output logic [XLEN-1:0]   upd_data,
   output logic              bad_form,
   output logic              align_err
);

   localparam int unsigned LANES   = XLEN / BYTE_W;
   localparam int unsigned LANE_AW = $clog2(LANES);

   generate
      if ((XLEN % BYTE_W) != 0 || XLEN < 2 * BYTE_W) begin : g_bad_xlen
         $error("ld_addr_fmt: XLEN must be a multiple of 8 and at least 16");
      end
      if (DISP_W > XLEN || DISP_W < 1) begin : g_bad_disp
         $error("ld_addr_fmt: DISP_W must lie in 1..XLEN");
      end
      if (RSEL_W < 1) begin : g_bad_rsel
         $error("ld_addr_fmt: RSEL_W must be at least 1");
      end
   endgenerate

   ld_state_e         state;
   logic [XLEN-1:0]   ea;
   logic [XLEN-1:0]   ea_q;
   logic [2:0]        kind_q;
   logic              upd_q;
   logic [RSEL_W-1:0] dst_q;
   logic [RSEL_W-1:0] base_q;
   logic              f_bad;
   logic              f_mis;
   logic              f_addr;
   logic [XLEN-1:0]   fmt_out;

   ld_ea_calc #(.XLEN(XLEN), .DISP_W(DISP_W), .RSEL_W(RSEL_W)) u_ea (
      .use_index (op_idx),
      .base_sel  (op_base_sel),
      .base_val  (op_base_val),
      .index_val (op_index_val),
      .disp      (op_disp),
      .ea        (ea)
   );

   ld_form_chk #(.RSEL_W(RSEL_W), .LANE_AW(LANE_AW), .ALLOW_REV(ALLOW_REV)) u_form (
      .kind      (op_kind),
      .upd       (op_upd),
      .base_sel  (op_base_sel),
      .dst_sel   (op_dst_sel),
      .ea_low    (ea[LANE_AW-1:0]),
      .bad       (f_bad),
      .misalign  (f_mis),
      .addr_only (f_addr)
   );

   ld_lane_fmt #(.XLEN(XLEN)) u_fmt (
      .word (mem_rdata),
      .off  (ea_q[LANE_AW-1:0]),
      .kind (kind_q),
      .data (fmt_out)
   );

   assign busy     = (state != ST_IDLE);
   assign mem_req  = (state == ST_REQ);
   assign mem_addr = {ea_q[XLEN-1:LANE_AW], {LANE_AW{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ea_q      <= '0;
         kind_q    <= '0;
         upd_q     <= 1'b0;
         dst_q     <= '0;
         base_q    <= '0;
         res_we    <= 1'b0;
         res_sel   <= '0;
         res_data  <= '0;
         upd_we    <= 1'b0;
         upd_sel   <= '0;
         upd_data  <= '0;
         bad_form  <= 1'b0;
         align_err <= 1'b0;
      end else begin
         res_we    <= 1'b0;
         upd_we    <= 1'b0;
         bad_form  <= 1'b0;
         align_err <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (op_valid) begin
                  ea_q   <= ea;
                  kind_q <= op_kind;
                  upd_q  <= op_upd;
                  dst_q  <= op_dst_sel;
                  base_q <= op_base_sel;
                  if (f_bad) begin
                     bad_form <= 1'b1;
                  end else if (f_mis) begin
                     align_err <= 1'b1;
                  end else if (f_addr) begin
                     res_we   <= 1'b1;
                     res_sel  <= op_dst_sel;
                     res_data <= ea;
                  end else begin
                     state <= ST_REQ;
                  end
               end
            end
            ST_REQ: state <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rvalid) begin
                  res_we   <= 1'b1;
                  res_sel  <= dst_q;
                  res_data <= fmt_out;
                  upd_we   <= upd_q;
                  upd_sel  <= base_q;
                  upd_data <= ea_q;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ld_addr_fmt_chk.sv
`timescale 1ns/1ps
module ld_addr_fmt_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned RSEL_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic [XLEN-1:0]   mem_addr,
   input logic              busy,
   input logic              res_we,
   input logic [RSEL_W-1:0] res_sel,
   input logic              upd_we,
   input logic [RSEL_W-1:0] upd_sel,
   input logic              bad_form,
   input logic              align_err
);

   // R4
   mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R4
   mem_addr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   // R10
   upd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |-> (res_we && (upd_sel != '0) && (upd_sel != res_sel)));

   // R12
   bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_form |-> (!res_we && !upd_we && !mem_req && !align_err));

   // R13
   align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (!res_we && !upd_we && !mem_req));

   // R14
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> mem_req);

   // R9
   res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> !busy);

endmodule

bind ld_addr_fmt ld_addr_fmt_chk #(.XLEN(XLEN), .RSEL_W(RSEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .busy      (busy),
   .res_we    (res_we),
   .res_sel   (res_sel),
   .upd_we    (upd_we),
   .upd_sel   (upd_sel),
   .bad_form  (bad_form),
   .align_err (align_err)
);

// File: tb/ld_addr_fmt_bench.sv
`timescale 1ns/1ps
module ld_addr_fmt_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_kind = '0;
   logic        op_idx = 1'b0;
   logic        op_upd = 1'b0;
   logic [4:0]  op_base_sel = '0;
   logic [4:0]  op_dst_sel = '0;
   logic [31:0] op_base_val = '0;
   logic [31:0] op_index_val = '0;
   logic [15:0] op_disp = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        busy;
   logic        res_we;
   logic [4:0]  res_sel;
   logic [31:0] res_data;
   logic        upd_we;
   logic [4:0]  upd_sel;
   logic [31:0] upd_data;
   logic        bad_form;
   logic        align_err;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   ld_addr_fmt u_ld_addr_fmt (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .op_kind      (op_kind),
      .op_idx       (op_idx),
      .op_upd       (op_upd),
      .op_base_sel  (op_base_sel),
      .op_dst_sel   (op_dst_sel),
      .op_base_val  (op_base_val),
      .op_index_val (op_index_val),
      .op_disp      (op_disp),
      .mem_req      (mem_req),
      .mem_addr     (mem_addr),
      .mem_rvalid   (mem_rvalid),
      .mem_rdata    (mem_rdata),
      .busy         (busy),
      .res_we       (res_we),
      .res_sel      (res_sel),
      .res_data     (res_data),
      .upd_we       (upd_we),
      .upd_sel      (upd_sel),
      .upd_data     (upd_data),
      .bad_form     (bad_form),
      .align_err    (align_err)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // word content of the bench memory model for any word address
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return ((a ^ 32'hA5C3_0F96) * 32'h9E37_79B1) + {a[15:0], a[31:16]};
   endfunction

   function automatic logic [31:0] exp_ea(input bit idx, input logic [4:0] bs,
                                          input logic [31:0] bv, input logic [31:0] iv,
                                          input logic [15:0] dv);
      logic [31:0] b;
      b = (bs == 5'd0) ? 32'd0 : bv;
      return idx ? b + iv : b + {{16{dv[15]}}, dv};
   endfunction

   function automatic logic [31:0] exp_fmt(input logic [2:0] k, input logic [31:0] w,
                                           input logic [1:0] off);
      logic [7:0] b0;
      logic [7:0] b1;
      logic [1:0] o1;
      o1 = off + 2'd1;
      b0 = w[31 - 8*off -: 8];
      b1 = w[31 - 8*o1 -: 8];
      case (k)
         3'd1:    return {24'd0, b0};
         3'd2:    return {16'd0, b0, b1};
         3'd3:    return {{16{b0[7]}}, b0, b1};
         3'd4:    return {16'd0, b1, b0};
         default: return 32'd0;
      endcase
   endfunction

   task automatic run_op(input logic [2:0] k, input bit idx, input bit upd,
                         input logic [4:0] bs, input logic [4:0] ds,
                         input logic [31:0] bv, input logic [31:0] iv,
                         input logic [15:0] dv, input int lat, input bit poke,
                         input string tag);
      logic [31:0] ea;
      logic [31:0] waddr;
      logic [31:0] w;
      bit bad;
      bit mis;
      ea  = exp_ea(idx, bs, bv, iv, dv);
      bad = (k > 3'd4) || (k == 3'd0 && (bs == 5'd0 || upd)) ||
            (upd && (bs == 5'd0 || bs == ds));
      mis = !bad && (k >= 3'd2 && k <= 3'd4) && (ea[1:0] == 2'd3);
      op_valid = 1'b1; op_kind = k; op_idx = idx; op_upd = upd;
      op_base_sel = bs; op_dst_sel = ds; op_base_val = bv;
      op_index_val = iv; op_disp = dv;
      @(negedge clk);
      op_valid = 1'b0;
      if (bad) begin
         // R12
         chk(bad_form == 1'b1, {tag, " R12 bad_form"}, 32'(bad_form), 1);
         chk(!res_we && !upd_we && !mem_req && !align_err, {tag, " R12 quiet"},
             {res_we, upd_we, mem_req, align_err}, 0);
      end else if (mis) begin
         // R13
         chk(align_err == 1'b1, {tag, " R13 align_err"}, 32'(align_err), 1);
         chk(!res_we && !upd_we && !mem_req && !bad_form, {tag, " R13 quiet"},
             {res_we, upd_we, mem_req, bad_form}, 0);
      end else if (k == 3'd0) begin
         // R11 (address from R1/R2)
         chk(res_we && !mem_req && !upd_we, {tag, " R11 strobes"},
             {res_we, mem_req, upd_we}, 32'h4);
         chk(res_data == ea, {tag, " R11 res_data"}, res_data, ea);
         chk(res_sel == ds, {tag, " R11 res_sel"}, 32'(res_sel), 32'(ds));
      end else begin
         waddr = {ea[31:2], 2'b00};
         // R4 request cycle, R14 busy
         chk(mem_req == 1'b1 && busy == 1'b1, {tag, " R4 mem_req"}, {mem_req, busy}, 3);
         chk(mem_addr == waddr, {tag, " R4 mem_addr"}, mem_addr, waddr);
         chk(res_we == 1'b0, {tag, " R9 early res_we"}, 32'(res_we), 0);
         @(negedge clk);
         if (poke) begin
            // R14: offer while busy must be dropped
            op_valid = 1'b1; op_kind = 3'd0; op_base_sel = 5'd1; op_upd = 1'b0;
         end
         for (int i = 1; i < lat; i++) begin
            chk(mem_req == 1'b0 && busy == 1'b1 && res_we == 1'b0, {tag, " R14 wait"},
                {mem_req, busy, res_we}, 32'h2);
            @(negedge clk);
         end
         w = mem_word(waddr);
         mem_rvalid = 1'b1; mem_rdata = w;
         @(negedge clk);
         mem_rvalid = 1'b0; mem_rdata = ~w; op_valid = 1'b0;
         // R9 result timing
         chk(res_we == 1'b1 && busy == 1'b0, {tag, " R9 res_we"}, {res_we, busy}, 2);
         chk(res_sel == ds, {tag, " R9 res_sel"}, 32'(res_sel), 32'(ds));
         // R5..R8 formatting
         chk(res_data == exp_fmt(k, w, ea[1:0]), {tag, " R5-8 res_data"},
             res_data, exp_fmt(k, w, ea[1:0]));
         if (upd) begin
            // R10
            chk(upd_we && upd_sel == bs && upd_data == ea, {tag, " R10 update"},
                upd_data, ea);
         end else begin
            chk(upd_we == 1'b0, {tag, " R10 no update"}, 32'(upd_we), 0);
         end
      end
      @(negedge clk);
      chk(!res_we && !bad_form && !align_err && !upd_we && !busy, {tag, " R14 idle after"},
          {res_we, bad_form, align_err, upd_we, busy}, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!res_we && !upd_we && !mem_req && !busy && !bad_form && !align_err,
          "reset outputs", {res_we, upd_we, mem_req, busy, bad_form, align_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: negative displacement, address only
      run_op(3'd0, 0, 0, 5'd3, 5'd4, 32'h0000_1000, 32'h0, 16'hFFF0, 1, 0, "R1 neg disp");
      // R1: wraparound
      run_op(3'd0, 0, 0, 5'd3, 5'd4, 32'hFFFF_FFF0, 32'h0, 16'h0020, 1, 0, "R1 wrap");
      // R2: indexed byte load
      run_op(3'd1, 1, 0, 5'd2, 5'd7, 32'h0000_4000, 32'h0000_0123, 16'h7FFF, 2, 0, "R2 index");
      // R3: zero base ignores base value
      run_op(3'd1, 0, 0, 5'd0, 5'd7, 32'hDEAD_BEEF, 32'h0, 16'h0102, 1, 0, "R3 zero base");
      // R5: byte at offset 3 is legal
      run_op(3'd1, 0, 0, 5'd5, 5'd6, 32'h0000_2003, 32'h0, 16'h0000, 1, 0, "R5 byte off3");
      // R6, R7, R8 at offsets 0..2
      for (int o = 0; o < 3; o++) begin
         run_op(3'd3, 0, 0, 5'd5, 5'd6, 32'h0000_3000 + o, 32'h0, 16'h0000, 1, 0, "R6 sign");
         run_op(3'd2, 0, 0, 5'd5, 5'd6, 32'h0000_3000 + o, 32'h0, 16'h0000, 2, 0, "R7 zero");
         run_op(3'd4, 0, 0, 5'd5, 5'd6, 32'h0000_3000 + o, 32'h0, 16'h0000, 3, 0, "R8 swap");
      end
      // R13: halfword at offset 3
      run_op(3'd3, 0, 0, 5'd5, 5'd6, 32'h0000_3003, 32'h0, 16'h0000, 1, 0, "R13 half off3");
      // R10: update form
      run_op(3'd2, 1, 1, 5'd8, 5'd9, 32'h0001_0000, 32'h0000_0042, 16'h0, 2, 0, "R10 upd");
      // R12: bad forms
      run_op(3'd5, 0, 0, 5'd1, 5'd2, 32'h0, 32'h0, 16'h0, 1, 0, "R12 kind5");
      run_op(3'd1, 0, 1, 5'd4, 5'd4, 32'h0, 32'h0, 16'h0, 1, 0, "R12 upd same");
      run_op(3'd1, 0, 1, 5'd0, 5'd4, 32'h0, 32'h0, 16'h0, 1, 0, "R12 upd zero");
      run_op(3'd0, 0, 0, 5'd0, 5'd4, 32'h0, 32'h0, 16'h4, 1, 0, "R12 addr zero");
      run_op(3'd0, 0, 1, 5'd3, 5'd4, 32'h0, 32'h0, 16'h4, 1, 0, "R12 addr upd");
      // R14: offer while busy is ignored
      run_op(3'd1, 0, 0, 5'd3, 5'd4, 32'h0000_5000, 32'h0, 16'h1, 3, 1, "R14 poke");
      // R9: stray response while idle
      mem_rvalid = 1'b1; mem_rdata = 32'h1234_5678;
      @(negedge clk);
      mem_rvalid = 1'b0;
      chk(!res_we && !upd_we && !busy, "R9 stray rvalid", {res_we, upd_we, busy}, 0);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [2:0]  k;
         logic [31:0] r;
         r = $urandom;
         k = (r[3:0] < 4'd13) ? 3'(1 + (r[7:4] % 4)) : ((r[3:0] == 4'd15) ? 3'(5 + r[9:8] % 3) : 3'd0);
         run_op(k, bit'($urandom % 2), bit'(($urandom % 4) == 0),
                5'($urandom % 4), 5'($urandom % 4), $urandom, $urandom,
                16'($urandom), int'(1 + $urandom % 3), bit'(($urandom % 8) == 0), "rand");
      end
      finish_run();
   end

endmodule